// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Fetch Controller

This block sits beside the fetch stage of a small in-order core and turns short counted loops into free backward jumps. It holds a small bank of loop contexts, two by default. Each context holds a body start address, the address of the last instruction in the body, and a remaining-iteration count. Every cycle it compares the fetch address with the end address of each context that is still running. If a running loop's final instruction is being fetched and more passes remain, the block steers the next fetch back to that loop's first instruction in the same cycle. It also takes one pass off the count. No stall cycle is spent on the jump.

The contexts are loaded in two ways. Dedicated loop-setup instructions drive a setup write port. Software can also read and write every field through a CSR-style port, so an interrupt handler can save a context and restore it. The lowest-numbered context has the highest priority and is meant to be the innermost loop. An inner loop that runs out is not re-armed by the block. The outer body re-arms it with a setup write, so nested counts multiply.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, every loop count reads 0, every start and end address reads 0, and `redirect_valid` is low.
- R2: When `fetch_valid` is high, the fetch address matches a loop's end address and that loop's count is greater than 1, then `redirect_valid` is high and `redirect_pc` equals that loop's start address. Both outputs are combinational and appear in the same cycle.
- R3: Each fetch that is accepted as a loop's end reduces that loop's count by exactly one at the next clock edge. When the count was 1, no redirect is produced and the count becomes 0.
- R4: A loop whose count is 0 is inactive. Fetching its end address gives no redirect and leaves the count at 0.
- R5: When several loops match the same fetch, only the lowest-numbered one acts. It alone produces the redirect and it alone is decremented. The counts of the other loops are unchanged.
- R6: Address bits [1:0] are forced to zero when a start or end address is written. Address matching ignores bits [1:0] of the fetch address.
- R7: The CSR address is {loop index, field}, where field 0 is start, 1 is end and 2 is count. Field 3 reads as zero and writes to it are ignored. `csr_rdata` follows `csr_addr` combinationally.
- R8: Setup and CSR writes take effect from the next clock edge. A CSR write wins over a setup write to the same field, and any write to a count wins over a decrement in the same cycle.
- R9: While `fetch_valid` is low, no redirect is produced and no count changes.
- R10: With an outer count M and an inner count N, where the outer body re-arms the inner count with a setup write each pass, the inner body runs N×M times and both counts end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | ADDR_W | Address of the instruction being fetched |
| redirect_valid | output | 1 | Next fetch must go to `redirect_pc` |
| redirect_pc | output | ADDR_W | Loop start address to fetch next |
| setup_we | input | 1 | Setup-instruction write strobe |
| setup_loop | input | LOOP_W | Loop index for the setup write |
| setup_fld | input | 2 | Field for the setup write (0 start, 1 end, 2 count) |
| setup_data | input | DATA_W | Setup write value |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | LOOP_W+2 | CSR address {loop, field} |
| csr_wdata | input | DATA_W | CSR write value |
| csr_rdata | output | DATA_W | CSR read value |

## Verification
The assertions take for granted that a written count never drops below what the decrement rule expects. They also take for granted that `fetch_valid` and the write strobes are known values once reset has been released. The stimulus keeps to this in three ways. Every input is driven at the falling edge from a defined idle state. Writes are only issued in cycles where the bench has computed the winning source on its own. Priority overlap of two loops is only created on purpose, in the scenario that checks R5. In the nested scenario the outer end address lies at least two instructions beyond the inner end, so each fetch matches at most one loop.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

   typedef enum logic [1:0] {
      FLD_START = 2'd0,
      FLD_END   = 2'd1,
      FLD_COUNT = 2'd2,
      FLD_NONE  = 2'd3
   } hwl_field_e;

   function automatic int unsigned loop_idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hwloop_regset.sv
module hwloop_regset
   import hwloop_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              setup_we,
   input  logic [1:0]        setup_fld,
   input  logic [DATA_W-1:0] setup_data,
   input  logic              csr_we,
   input  logic [1:0]        csr_fld,
   input  logic [DATA_W-1:0] csr_data,
   input  logic              dec,
   output logic [ADDR_W-1:0] start_q,
   output logic [ADDR_W-1:0] end_q,
   output logic [CNT_W-1:0]  count_q
);

   logic csr_start_wr, csr_end_wr, csr_cnt_wr;
   logic set_start_wr, set_end_wr, set_cnt_wr;
   logic cnt_wr;
   logic [ADDR_W-1:0] csr_addr_al, set_addr_al;

   assign csr_start_wr = csr_we   && (csr_fld   == FLD_START);
   assign csr_end_wr   = csr_we   && (csr_fld   == FLD_END);
   assign csr_cnt_wr   = csr_we   && (csr_fld   == FLD_COUNT);
   assign set_start_wr = setup_we && (setup_fld == FLD_START);
   assign set_end_wr   = setup_we && (setup_fld == FLD_END);
   assign set_cnt_wr   = setup_we && (setup_fld == FLD_COUNT);
   assign cnt_wr       = csr_cnt_wr || set_cnt_wr;

   assign csr_addr_al = {csr_data[ADDR_W-1:2], 2'b00};
   assign set_addr_al = {setup_data[ADDR_W-1:2], 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
      end else begin
         if (csr_start_wr)      start_q <= csr_addr_al;
         else if (set_start_wr) start_q <= set_addr_al;
         if (csr_end_wr)        end_q   <= csr_addr_al;
         else if (set_end_wr)   end_q   <= set_addr_al;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (csr_cnt_wr) begin
         count_q <= csr_data[CNT_W-1:0];
      end else if (set_cnt_wr) begin
         count_q <= setup_data[CNT_W-1:0];
      end else if (dec) begin
         count_q <= count_q - CNT_W'(1);
      end
   end

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !cnt_wr) |=> (count_q == $past(count_q) - CNT_W'(1)));

   assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !cnt_wr) |=> $stable(count_q));

   assert_csr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      csr_cnt_wr |=> (count_q == $past(csr_data[CNT_W-1:0])));

   assert_dec_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (count_q != '0));

   assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q[1:0] == 2'b00) && (end_q[1:0] == 2'b00));

endmodule

// File: rtl/hwloop_match.sv
module hwloop_match #(
   parameter int unsigned NUM_LOOPS = 2,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                fetch_valid,
   input  logic [ADDR_W-1:0]                   fetch_pc,
   input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]    start_a,
   input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]    end_a,
   input  logic [NUM_LOOPS-1:0][CNT_W-1:0]     count_a,
   output logic [NUM_LOOPS-1:0]                dec,
   output logic                                redirect_valid,
   output logic [ADDR_W-1:0]                   redirect_pc
);

   logic [NUM_LOOPS-1:0] hit;
   logic [NUM_LOOPS-1:0] more;
   logic                 unused_pc_lsb;
   logic                 unused_end_lsb;

   assign unused_pc_lsb = ^fetch_pc[1:0];

   for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_cmp
      assign hit[g]  = fetch_valid && (count_a[g] != '0) &&
                       (fetch_pc[ADDR_W-1:2] == end_a[g][ADDR_W-1:2]);
      assign more[g] = count_a[g] > CNT_W'(1);
   end

   always_comb begin
      logic found;
      found = 1'b0;
      dec   = '0;
      for (int i = 0; i < NUM_LOOPS; i++) begin
         if (hit[i] && !found) begin
            dec[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   always_comb begin
      redirect_pc = '0;
      for (int i = 0; i < NUM_LOOPS; i++) begin
         if (dec[i]) redirect_pc = redirect_pc | start_a[i];
      end
   end

   assign redirect_valid = |(dec & more);

   always_comb begin
      unused_end_lsb = 1'b0;
      for (int i = 0; i < NUM_LOOPS; i++) unused_end_lsb = unused_end_lsb ^ (^end_a[i][1:0]);
   end

   assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec));

   assert_inner_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit[0] |-> dec[0]);

   assert_redirect_needs_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> fetch_valid);

   assert_redirect_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (redirect_pc[1:0] == 2'b00));

endmodule

// File: rtl/hwloop_csr_mux.sv
module hwloop_csr_mux
   import hwloop_pkg::*;
#(
   parameter int unsigned NUM_LOOPS = 2,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned DATA_W    = 32,
   localparam int unsigned LOOP_W   = loop_idx_width(NUM_LOOPS),
   localparam int unsigned CSR_AW   = LOOP_W + 2
) (
   input  logic [CSR_AW-1:0]                   csr_addr,
   input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]    start_a,
   input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]    end_a,
   input  logic [NUM_LOOPS-1:0][CNT_W-1:0]     count_a,
   output logic [DATA_W-1:0]                   csr_rdata
);

   logic [LOOP_W-1:0] idx;
   logic [1:0]        fld;

   assign idx = csr_addr[CSR_AW-1:2];
   assign fld = csr_addr[1:0];

   always_comb begin
      csr_rdata = '0;
      for (int i = 0; i < NUM_LOOPS; i++) begin
         if (idx == LOOP_W'(i)) begin
            unique case (fld)
               FLD_START: csr_rdata = DATA_W'(start_a[i]);
               FLD_END:   csr_rdata = DATA_W'(end_a[i]);
               FLD_COUNT: csr_rdata = DATA_W'(count_a[i]);
               default:   csr_rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
   import hwloop_pkg::*;
#(
   parameter int unsigned NUM_LOOPS = 2,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned DATA_W    = 32,
   localparam int unsigned LOOP_W   = loop_idx_width(NUM_LOOPS),
   localparam int unsigned CSR_AW   = LOOP_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_pc,
   input  logic              setup_we,
   input  logic [LOOP_W-1:0] setup_loop,
   input  logic [1:0]        setup_fld,
   input  logic [DATA_W-1:0] setup_data,
   input  logic              csr_we,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata
);

   if (NUM_LOOPS < 1)   begin : g_bad_loops $error("NUM_LOOPS must be at least 1"); end
   if (ADDR_W < 3)      begin : g_bad_addr  $error("ADDR_W must be at least 3"); end
   if (ADDR_W > DATA_W) begin : g_bad_aw    $error("ADDR_W must not exceed DATA_W"); end
   if (CNT_W > DATA_W)  begin : g_bad_cw    $error("CNT_W must not exceed DATA_W"); end
   if (CNT_W < 2)       begin : g_bad_cnt   $error("CNT_W must be at least 2"); end

   logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_a;
   logic [NUM_LOOPS-1:0][ADDR_W-1:0] end_a;
   logic [NUM_LOOPS-1:0][CNT_W-1:0]  count_a;
   logic [NUM_LOOPS-1:0]             dec;

   for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
      logic set_hit, csr_hit;
      assign set_hit = setup_we && (setup_loop == LOOP_W'(g));
      assign csr_hit = csr_we   && (csr_addr[CSR_AW-1:2] == LOOP_W'(g));

      hwloop_regset #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .DATA_W (DATA_W)
      ) i_regset (
         .clk        (clk),
         .rst_n      (rst_n),
         .setup_we   (set_hit),
         .setup_fld  (setup_fld),
         .setup_data (setup_data),
         .csr_we     (csr_hit),
         .csr_fld    (csr_addr[1:0]),
         .csr_data   (csr_wdata),
         .dec        (dec[g]),
         .start_q    (start_a[g]),
         .end_q      (end_a[g]),
         .count_q    (count_a[g])
      );
   end

   hwloop_match #(
      .NUM_LOOPS (NUM_LOOPS),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W)
   ) i_match (
      .clk            (clk),
      .rst_n          (rst_n),
      .fetch_valid    (fetch_valid),
      .fetch_pc       (fetch_pc),
      .start_a        (start_a),
      .end_a          (end_a),
      .count_a        (count_a),
      .dec            (dec),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc)
   );

   hwloop_csr_mux #(
      .NUM_LOOPS (NUM_LOOPS),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .DATA_W    (DATA_W)
   ) i_csr_mux (
      .csr_addr  (csr_addr),
      .start_a   (start_a),
      .end_a     (end_a),
      .count_a   (count_a),
      .csr_rdata (csr_rdata)
   );

   assert_fetch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid && !csr_we && !setup_we) |=> $stable(count_a));

   assert_redirect_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_valid && dec[0]) |-> (redirect_pc == start_a[0]));

endmodule

// File: tb/test_hwloop_ctrl.sv
module test_hwloop_ctrl;

   localparam int unsigned AW = 32;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_valid = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic          redirect_valid;
   logic [AW-1:0] redirect_pc;
   logic          setup_we = 1'b0;
   logic [0:0]    setup_loop = '0;
   logic [1:0]    setup_fld = '0;
   logic [DW-1:0] setup_data = '0;
   logic          csr_we = 1'b0;
   logic [2:0]    csr_addr = '0;
   logic [DW-1:0] csr_wdata = '0;
   logic [DW-1:0] csr_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   hwloop_ctrl i_hwloop_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .fetch_valid    (fetch_valid),
      .fetch_pc       (fetch_pc),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .setup_we       (setup_we),
      .setup_loop     (setup_loop),
      .setup_fld      (setup_fld),
      .setup_data     (setup_data),
      .csr_we         (csr_we),
      .csr_addr       (csr_addr),
      .csr_wdata      (csr_wdata),
      .csr_rdata      (csr_rdata)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // advance one clock; inputs stay driven from the falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      fetch_valid = 1'b0;
      setup_we    = 1'b0;
      csr_we      = 1'b0;
   endtask

   task automatic csr_wr(input int loop, input int fld, input logic [DW-1:0] val);
      csr_we    = 1'b1;
      csr_addr  = 3'((loop << 2) | fld);
      csr_wdata = val;
      step();
      csr_we    = 1'b0;
   endtask

   task automatic csr_rd(input int loop, input int fld, output logic [DW-1:0] val);
      csr_addr = 3'((loop << 2) | fld);
      #1;
      val = csr_rdata;
   endtask

   task automatic arm(input int loop, input logic [AW-1:0] s, input logic [AW-1:0] e,
                      input logic [DW-1:0] c);
      csr_wr(loop, 0, s);
      csr_wr(loop, 1, e);
      csr_wr(loop, 2, c);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      #1;
      check("R1 redirect after reset", {31'd0, redirect_valid}, 32'd0);
      for (int l = 0; l < 2; l++) begin
         for (int f = 0; f < 3; f++) begin
            csr_rd(l, f, v);
            check("R1 register after reset", v, 32'd0);
         end
      end
   endtask

   task automatic t_csr_map();
      logic [DW-1:0] v;
      csr_wr(1, 0, 32'h0000_1003);
      csr_rd(1, 0, v);
      check("R6 start low bits cleared", v, 32'h0000_1000);
      csr_wr(1, 2, 32'd77);
      csr_rd(1, 2, v);
      check("R7 count field of loop 1", v, 32'd77);
      csr_rd(0, 2, v);
      check("R7 loop 0 count untouched", v, 32'd0);
      csr_wr(1, 3, 32'hFFFF_FFFF);
      csr_rd(1, 3, v);
      check("R7 field 3 reads zero", v, 32'd0);
      csr_rd(1, 2, v);
      check("R7 field 3 write ignored", v, 32'd77);
      csr_wr(1, 2, 32'd0);
   endtask

   task automatic t_single();
      logic [DW-1:0] v;
      arm(0, 32'h40, 32'h4B, 32'd3);
      csr_rd(0, 1, v);
      check("R6 end low bits cleared", v, 32'h48);
      fetch_valid = 1'b1;
      fetch_pc    = 32'h4A;
      #1;
      check("R2 redirect valid (pc low bits ignored, R6)", {31'd0, redirect_valid}, 32'd1);
      check("R2 redirect target", redirect_pc, 32'h40);
      step();
      fetch_pc = 32'h48;
      csr_rd(0, 2, v);
      check("R3 count after first pass", v, 32'd2);
      check("R2 redirect second pass", {31'd0, redirect_valid}, 32'd1);
      step();
      csr_rd(0, 2, v);
      check("R3 count reaches 1", v, 32'd1);
      check("R3 last pass falls through", {31'd0, redirect_valid}, 32'd0);
      step();
      csr_rd(0, 2, v);
      check("R3 count reaches 0", v, 32'd0);
      check("R4 inactive loop no redirect", {31'd0, redirect_valid}, 32'd0);
      step();
      csr_rd(0, 2, v);
      check("R4 count stays 0", v, 32'd0);
      idle();
   endtask

   task automatic t_no_fetch();
      logic [DW-1:0] v;
      csr_wr(0, 2, 32'd2);
      fetch_valid = 1'b0;
      fetch_pc    = 32'h48;
      #1;
      check("R9 no redirect without fetch", {31'd0, redirect_valid}, 32'd0);
      step();
      csr_rd(0, 2, v);
      check("R9 count held without fetch", v, 32'd2);
      csr_wr(0, 2, 32'd0);
   endtask

   task automatic t_priority();
      logic [DW-1:0] v;
      arm(0, 32'h70, 32'h80, 32'd2);
      arm(1, 32'h60, 32'h80, 32'd5);
      fetch_valid = 1'b1;
      fetch_pc    = 32'h80;
      #1;
      check("R5 redirect taken", {31'd0, redirect_valid}, 32'd1);
      check("R5 loop 0 target wins", redirect_pc, 32'h70);
      step();
      idle();
      csr_rd(0, 2, v);
      check("R5 loop 0 decremented", v, 32'd1);
      csr_rd(1, 2, v);
      check("R5 loop 1 untouched", v, 32'd5);
      csr_wr(0, 2, 32'd0);
      csr_wr(1, 2, 32'd0);
   endtask

   task automatic t_precedence();
      logic [DW-1:0] v;
      arm(0, 32'h40, 32'h48, 32'd3);
      fetch_valid = 1'b1;
      fetch_pc    = 32'h48;
      csr_we      = 1'b1;
      csr_addr    = 3'd2;
      csr_wdata   = 32'd7;
      setup_we    = 1'b1;
      setup_loop  = 1'b0;
      setup_fld   = 2'd2;
      setup_data  = 32'd9;
      #1;
      check("R8 redirect uses old state", {31'd0, redirect_valid}, 32'd1);
      step();
      csr_we = 1'b0;
      fetch_valid = 1'b0;
      csr_rd(0, 2, v);
      check("R8 CSR write beats setup and decrement", v, 32'd7);
      fetch_valid = 1'b1;
      step();
      setup_we = 1'b0;
      fetch_valid = 1'b0;
      csr_rd(0, 2, v);
      check("R8 setup write beats decrement", v, 32'd9);
      setup_we   = 1'b1;
      setup_fld  = 2'd1;
      setup_data = 32'h58;
      step();
      setup_we    = 1'b0;
      fetch_valid = 1'b1;
      fetch_pc    = 32'h58;
      #1;
      check("R8 new end used on next fetch", {31'd0, redirect_valid}, 32'd1);
      step();
      idle();
      csr_wr(0, 2, 32'd0);
   endtask

   task automatic t_nested();
      logic [DW-1:0] v;
      logic [AW-1:0] pc, nxt;
      int inner;
      int guard;
      arm(1, 32'hF8, 32'h110, 32'd4);
      arm(0, 32'h100, 32'h108, 32'd0);
      pc = 32'hF8;
      inner = 0;
      guard = 0;
      while (pc != 32'h114 && guard < 400) begin
         fetch_valid = 1'b1;
         fetch_pc    = pc;
         setup_we    = (pc == 32'hF8);
         setup_loop  = 1'b0;
         setup_fld   = 2'd2;
         setup_data  = 32'd3;
         #1;
         if (pc == 32'h100) inner++;
         nxt = redirect_valid ? redirect_pc : pc + 32'd4;
         step();
         pc = nxt;
         guard++;
      end
      idle();
      check("R10 nested inner body passes", 32'(inner), 32'd12);
      check("R10 loop exits at 0x114", pc, 32'h114);
      csr_rd(0, 2, v);
      check("R10 inner count ends 0", v, 32'd0);
      csr_rd(1, 2, v);
      check("R10 outer count ends 0", v, 32'd0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_csr_map();
      t_single();
      t_no_fetch();
      t_priority();
      t_precedence();
      t_nested();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule